// File: doc/BRIEF.md
# PHY Link Duplex Resolver

This block runs one link-resolution pass against an external Ethernet PHY each time `start` is pulsed. It talks to a separate MDIO master through a request/response port. Each pass reads the PHY status register (address 1) and then the link-partner ability register (address 5). From those values it decides whether a PHY answers at all, whether the link is up, and which speed class and duplex both ends share. It then rewrites two bits of a 32-bit MAC operating-mode word. One is the full-duplex bit. The other is a transmit-threshold bit, which is set for 10 Mb/s operation and cleared for 100 Mb/s.

The link bit in the status register latches low. A cleared link bit therefore earns exactly one more read of register 1 before the block gives up. Each pass ends with a one-cycle `done` pulse and a two-bit result code. When the mode word actually changes, the block also gives a one-cycle `restart` pulse, so the MAC datapath can restart its transmit and receive engines.

Request side rules: `req_valid` rises only in the block's own request states. While `req_ready` is low, `req_valid`, `req_phy` and `req_reg` hold steady. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. Response side rules: `rsp_ready` is high only while one answer is awaited. A response word is taken on an edge where `rsp_valid` and `rsp_ready` are both high. Only one transaction is ever in flight. All other pins are plain level or pulse signals.

Top module: `phy_duplex_resolver`

## Requirements
- R1: A `start` pulse seen while `busy` is low begins a pass. The pass captures `phy_addr`, `local_adv` and `fd_lock` at that edge, then requests register 1 and then register 5 from the captured PHY address. A `start` pulse while `busy` is high is ignored.
- R2: While `req_valid` is high and `req_ready` is low, the request stays valid and its fields stay unchanged. `req_valid` and `rsp_ready` are never high together, and neither is high while `busy` is low.
- R3: If the first status word equals 0xFFFF, the result is code 3 (PHY absent). The mode word is left as it was and `restart` stays low.
- R4: If bit 2 (link) of the first status word is clear, exactly one further read of register 1 is made. If bit 2 of that word is also clear, the result is code 2 (no link) and the mode word is left as it was.
- R5: If bit 2 of the first status word is set, no third request is made.
- R6: The negotiated set is the partner word ANDed with `local_adv`. If any of bits 9, 8 or 7 of that set is 1, the transmit-threshold bit (parameter `TH_BIT`) is cleared. Otherwise it is set.
- R7: Full duplex is chosen when `fd_lock` is high, or bit 8 of the negotiated set is 1, or bits 8..6 of the negotiated set equal 3'b001. Bit 9 of the mode word takes the chosen duplex.
- R8: All other mode-word bits are kept. If the resolved word differs from the stored one, it is stored, `restart` pulses, and the result is code 1 (changed). Otherwise the result is code 0 (unchanged) and `restart` stays low.
- R9: After reset, the mode word equals `MODE_INIT`, and `busy`, `done`, `restart` and `req_valid` are low.
- R10: `done` is high for exactly one cycle, two clock edges after the last response is accepted. `restart`, `result` and the new mode word are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one resolution pass |
| phy_addr | input | 5 | PHY address used by the pass |
| local_adv | input | 16 | Local advertisement word |
| fd_lock | input | 1 | Force full duplex |
| busy | output | 1 | Pass in progress |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | MDIO master accepts request |
| req_phy | output | 5 | Request PHY address |
| req_reg | output | 5 | Request register address |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Block awaits read data |
| rsp_data | input | 16 | Read data |
| mode_word | output | 32 | MAC operating-mode word |
| restart | output | 1 | One-cycle pulse on mode change |
| done | output | 1 | One-cycle end-of-pass pulse |
| result | output | 2 | 0 unchanged, 1 changed, 2 no link, 3 absent |

## Verification
The assertions assume the MDIO master returns exactly one response for each accepted request. They also assume it never asserts `rsp_valid` as a stray pulse that would matter outside a wait state. The stimulus keeps to this rule: its responder answers every accepted request once, after a chosen stall, and holds `rsp_valid` for exactly one accepting edge. The responder also holds off `req_ready` for several cycles to exercise request back-pressure. After each `start`, the bench changes `local_adv` and `fd_lock` to show that only the values captured at `start` are used.

// File: rtl/phy_duplex_resolver_pkg.sv
package phy_duplex_resolver_pkg;

  // MII management register addresses
  localparam logic [4:0] REG_STATUS  = 5'd1;
  localparam logic [4:0] REG_PARTNER = 5'd5;

  // status register fields
  localparam int unsigned LINK_BIT     = 2;
  localparam logic [15:0] ABSENT_WORD  = 16'hFFFF;

  // ability slice kept from partner/advertisement words (bits 9..6)
  localparam int unsigned ABIL_LO = 6;
  localparam int unsigned ABIL_HI = 9;
  localparam int unsigned ABIL_W  = ABIL_HI - ABIL_LO + 1;

  // positions inside the slice
  localparam int unsigned AB_T4   = 3;
  localparam int unsigned AB_TXFD = 2;
  localparam int unsigned AB_TXHD = 1;
  localparam int unsigned AB_TFD  = 0;

  typedef enum logic [1:0] {
    RES_SAME    = 2'd0,
    RES_CHANGED = 2'd1,
    RES_NOLINK  = 2'd2,
    RES_ABSENT  = 2'd3
  } res_e;

  typedef enum logic [1:0] {
    V_RESOLVE = 2'd0,
    V_NOLINK  = 2'd1,
    V_ABSENT  = 2'd2
  } verdict_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ASK_ST,
    S_GET_ST,
    S_ASK_LP,
    S_GET_LP,
    S_ASK_RE,
    S_GET_RE,
    S_EVAL
  } seq_e;

endpackage

// File: rtl/pdr_sequencer.sv
module pdr_sequencer
  import phy_duplex_resolver_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [DATA_W-1:0] local_adv,
  input  logic              fd_lock,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_phy,
  output logic [ADDR_W-1:0] req_reg,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              eval_go,
  output verdict_e          verdict,
  output logic [ABIL_W-1:0] partner_abil,
  output logic [ABIL_W-1:0] adv_abil,
  output logic              lock_q
);

  seq_e              state;
  logic [ADDR_W-1:0] phy_q;
  logic [DATA_W-1:0] status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      phy_q        <= '0;
      status_q     <= '0;
      partner_abil <= '0;
      adv_abil     <= '0;
      lock_q       <= 1'b0;
      verdict      <= V_RESOLVE;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          phy_q    <= phy_addr;
          adv_abil <= local_adv[ABIL_HI:ABIL_LO];
          lock_q   <= fd_lock;
          state    <= S_ASK_ST;
        end
        S_ASK_ST: if (req_ready) state <= S_GET_ST;
        S_GET_ST: if (rsp_valid) begin
          status_q <= rsp_data;
          state    <= S_ASK_LP;
        end
        S_ASK_LP: if (req_ready) state <= S_GET_LP;
        S_GET_LP: if (rsp_valid) begin
          partner_abil <= rsp_data[ABIL_HI:ABIL_LO];
          if (status_q == ABSENT_WORD) begin
            verdict <= V_ABSENT;
            state   <= S_EVAL;
          end else if (status_q[LINK_BIT]) begin
            verdict <= V_RESOLVE;
            state   <= S_EVAL;
          end else begin
            state   <= S_ASK_RE;   // latched-low link bit: one retry
          end
        end
        S_ASK_RE: if (req_ready) state <= S_GET_RE;
        S_GET_RE: if (rsp_valid) begin
          verdict <= rsp_data[LINK_BIT] ? V_RESOLVE : V_NOLINK;
          state   <= S_EVAL;
        end
        S_EVAL: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_valid = (state == S_ASK_ST) || (state == S_ASK_LP) || (state == S_ASK_RE);
    rsp_ready = (state == S_GET_ST) || (state == S_GET_LP) || (state == S_GET_RE);
    req_reg   = (state == S_ASK_LP) ? REG_PARTNER : REG_STATUS;
    req_phy   = phy_q;
    busy      = (state != S_IDLE);
    eval_go   = (state == S_EVAL);
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_reg) && $stable(req_phy)); // R2
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !rsp_ready); // R2
  AST_EVAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eval_go |=> !eval_go && !busy); // R10

endmodule

// File: rtl/pdr_ability_resolve.sv
module pdr_ability_resolve
  import phy_duplex_resolver_pkg::*;
#(
  parameter int unsigned MODE_W = 32,
  parameter int unsigned TH_BIT = 22,
  parameter int unsigned FD_BIT = 9
) (
  input  logic [ABIL_W-1:0] partner_abil,
  input  logic [ABIL_W-1:0] adv_abil,
  input  logic              lock,
  input  logic [MODE_W-1:0] cur_mode,
  output logic [MODE_W-1:0] next_mode
);

  logic [ABIL_W-1:0] common;
  logic              fast;
  logic              full;

  always_comb begin
    common = partner_abil & adv_abil;
    fast   = common[AB_T4] | common[AB_TXFD] | common[AB_TXHD];
    full   = lock | common[AB_TXFD]
           | (common[AB_TFD] & ~common[AB_TXHD] & ~common[AB_TXFD]);
    next_mode         = cur_mode;
    next_mode[TH_BIT] = ~fast;
    next_mode[FD_BIT] = full;
  end

endmodule

// File: rtl/pdr_mode_store.sv
module pdr_mode_store
  import phy_duplex_resolver_pkg::*;
#(
  parameter int unsigned      MODE_W    = 32,
  parameter logic [MODE_W-1:0] MODE_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_go,
  input  verdict_e          verdict,
  input  logic [MODE_W-1:0] next_mode,
  output logic [MODE_W-1:0] mode_word,
  output logic              restart,
  output logic              done,
  output res_e              result
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_word <= MODE_INIT;
      restart   <= 1'b0;
      done      <= 1'b0;
      result    <= RES_SAME;
    end else begin
      restart <= 1'b0;
      done    <= eval_go;
      if (eval_go) begin
        unique case (verdict)
          V_ABSENT: result <= RES_ABSENT;
          V_NOLINK: result <= RES_NOLINK;
          default: begin
            if (next_mode != mode_word) begin
              mode_word <= next_mode;
              restart   <= 1'b1;
              result    <= RES_CHANGED;
            end else begin
              result    <= RES_SAME;
            end
          end
        endcase
      end
    end
  end

  AST_RESTART_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> mode_word != $past(mode_word)); // R8
  AST_CHANGE_MEANS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    mode_word != $past(mode_word) |-> restart && done && result == RES_CHANGED); // R8
  AST_ABSENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done && result == RES_ABSENT |-> $stable(mode_word) && !restart); // R3
  AST_NOLINK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done && result == RES_NOLINK |-> $stable(mode_word) && !restart); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

endmodule

// File: rtl/phy_duplex_resolver.sv
module phy_duplex_resolver
  import phy_duplex_resolver_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 5,
  parameter int unsigned       DATA_W    = 16,
  parameter int unsigned       MODE_W    = 32,
  parameter int unsigned       TH_BIT    = 22,
  parameter int unsigned       FD_BIT    = 9,
  parameter logic [MODE_W-1:0] MODE_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [DATA_W-1:0] local_adv,
  input  logic              fd_lock,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_phy,
  output logic [ADDR_W-1:0] req_reg,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [MODE_W-1:0] mode_word,
  output logic              restart,
  output logic              done,
  output logic [1:0]        result
);

  logic              eval_go;
  verdict_e          verdict;
  logic [ABIL_W-1:0] partner_abil;
  logic [ABIL_W-1:0] adv_abil;
  logic              lock_q;
  logic [MODE_W-1:0] next_mode;
  res_e              res_q;

  pdr_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk, .rst_n, .start, .phy_addr, .local_adv, .fd_lock, .busy,
    .req_valid, .req_ready, .req_phy, .req_reg,
    .rsp_valid, .rsp_ready, .rsp_data,
    .eval_go, .verdict, .partner_abil, .adv_abil, .lock_q
  );

  pdr_ability_resolve #(.MODE_W(MODE_W), .TH_BIT(TH_BIT), .FD_BIT(FD_BIT)) u_res (
    .partner_abil, .adv_abil, .lock(lock_q), .cur_mode(mode_word), .next_mode
  );

  pdr_mode_store #(.MODE_W(MODE_W), .MODE_INIT(MODE_INIT)) u_store (
    .clk, .rst_n, .eval_go, .verdict, .next_mode,
    .mode_word, .restart, .done, .result(res_q)
  );

  assign result = res_q;

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy && req_valid && req_reg == REG_STATUS); // R1
  AST_DONE_ENDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

endmodule

// File: tb/phy_duplex_resolver_bench.sv
module phy_duplex_resolver_bench;
  localparam int unsigned TH = 22;
  localparam logic [31:0] INIT = 32'h0202_0011;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0, fd_lock = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [15:0] local_adv = '0;
  logic        busy, req_valid, req_ready = 1'b0, rsp_valid = 1'b0, rsp_ready;
  logic [4:0]  req_phy, req_reg;
  logic [15:0] rsp_data = '0;
  logic [31:0] mode_word;
  logic        restart, done;
  logic [1:0]  result;

  phy_duplex_resolver #(.TH_BIT(TH), .MODE_INIT(INIT)) u_phy_duplex_resolver (
    .clk, .rst_n, .start, .phy_addr, .local_adv, .fd_lock, .busy,
    .req_valid, .req_ready, .req_phy, .req_reg,
    .rsp_valid, .rsp_ready, .rsp_data,
    .mode_word, .restart, .done, .result
  );

  int checks = 0, fails = 0;
  logic [31:0] exp_mode = INIT;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock reference comparison outside end-of-pass cycles (R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(restart == 1'b0, "R8 restart only with done", {31'd0, restart}, 32'd0);
      chk(mode_word == exp_mode, "R8 mode word held", mode_word, exp_mode);
    end
  end

  // R6/R7 reference
  function automatic logic [31:0] model(input logic [31:0] cur, input logic [15:0] lpa,
                                        input logic [15:0] adv, input bit lk);
    logic [15:0] n;
    bit fast, full;
    n = lpa & adv;
    fast = (n & 16'h0380) != 0;
    full = lk || n[8] || ((n & 16'h01C0) == 16'h0040);
    model = cur;
    model[TH] = !fast;
    model[9] = full;
  endfunction

  task automatic serve(input logic [4:0] pa, input logic [4:0] rg, input logic [15:0] data,
                       input int lat, input string tag);
    int n = 0;
    while (!req_valid && n < 40) begin @(negedge clk); n++; end
    chk(req_valid, tag, {31'd0, req_valid}, 32'd1);
    chk(req_reg == rg, tag, {27'd0, req_reg}, {27'd0, rg});
    chk(req_phy == pa, "R1 captured phy address", {27'd0, req_phy}, {27'd0, pa});
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(req_valid && req_reg == rg && req_phy == pa, "R2 request held under stall",
          {26'd0, req_valid, req_reg}, {26'd1, rg});
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    for (int i = 0; i < lat; i++) begin
      chk(rsp_ready && !req_valid, "R2 awaiting response only",
          {30'd0, rsp_ready, req_valid}, 32'd2);
      @(negedge clk);
    end
    chk(rsp_ready, "R2 rsp_ready while waiting", {31'd0, rsp_ready}, 32'd1);
    rsp_valid = 1'b1;
    rsp_data = data;
    @(negedge clk);
    rsp_valid = 1'b0;
    rsp_data = 16'h0;
  endtask

  task automatic do_pass(input logic [15:0] s1, input logic [15:0] lpa, input logic [15:0] s2,
                         input logic [15:0] adv, input bit lk, input logic [4:0] pa,
                         input int lat, input bit poke);
    bit absent, relink;
    logic [31:0] nxt;
    logic [1:0] code;
    local_adv = adv; fd_lock = lk; phy_addr = pa; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    local_adv = ~adv; fd_lock = !lk; phy_addr = ~pa;   // R1: must be ignored
    chk(busy, "R1 busy after start", {31'd0, busy}, 32'd1);
    serve(pa, 5'd1, s1, lat, "R1 first read register 1");
    if (poke) begin start = 1'b1; @(negedge clk); start = 1'b0; end
    serve(pa, 5'd5, lpa, lat, "R1 second read register 5");
    absent = (s1 == 16'hFFFF);
    relink = !absent && !s1[2];
    if (relink) serve(pa, 5'd1, s2, lat, "R4 re-read of register 1");
    if (absent) begin code = 2'd3; nxt = exp_mode; end
    else if (relink && !s2[2]) begin code = 2'd2; nxt = exp_mode; end
    else begin
      nxt = model(exp_mode, lpa, adv, lk);
      code = (nxt != exp_mode) ? 2'd1 : 2'd0;
    end
    chk(!req_valid, "R5 no further request", {31'd0, req_valid}, 32'd0);
    chk(!done, "R10 done not early", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk(done, "R10 done two edges after last response", {31'd0, done}, 32'd1);
    chk(result == code, (code == 3) ? "R3 absent code" : (code == 2) ? "R4 no-link code" :
        "R8 result code", {30'd0, result}, {30'd0, code});
    chk(mode_word == nxt, "R6 R7 resolved mode word", mode_word, nxt);
    chk(restart == (code == 2'd1), "R8 restart on change", {31'd0, restart}, {31'd0, code == 2'd1});
    exp_mode = nxt;
    @(negedge clk);
    chk(!done && !restart, "R10 single-cycle pulses", {30'd0, done, restart}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      chk(!busy && !req_valid, "R1 no pass from ignored start", {30'd0, busy, req_valid}, 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mode_word == INIT, "R9 reset mode word", mode_word, INIT);
    chk(!busy && !done && !restart && !req_valid, "R9 reset controls",
        {28'd0, busy, done, restart, req_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // 100 full common -> FD set, threshold cleared
    do_pass(16'h786D, 16'h45E1, 16'h0, 16'h01E1, 1'b0, 5'd1, 0, 1'b0);
    do_pass(16'h786D, 16'h45E1, 16'h0, 16'h01E1, 1'b0, 5'd1, 2, 1'b0);   // unchanged
    do_pass(16'h786D, 16'h0061, 16'h0, 16'h01E1, 1'b0, 5'd3, 1, 1'b0);   // 10 full best
    do_pass(16'h786D, 16'h0021, 16'h0, 16'h01E1, 1'b0, 5'd3, 3, 1'b0);   // 10 half
    do_pass(16'h786D, 16'h0021, 16'h0, 16'h01E1, 1'b1, 5'd7, 0, 1'b0);   // lock forces FD
    do_pass(16'hFFFF, 16'h01E1, 16'h0, 16'h01E1, 1'b0, 5'd9, 1, 1'b0);   // R3 absent
    do_pass(16'h7869, 16'h01E1, 16'h7869, 16'h01E1, 1'b0, 5'd2, 2, 1'b0); // R4 no link
    do_pass(16'h7869, 16'h00A1, 16'h786D, 16'h01E1, 1'b0, 5'd2, 1, 1'b0); // R4 retry ok
    do_pass(16'h786D, 16'h01E1, 16'h0, 16'h00E1, 1'b0, 5'd4, 0, 1'b0);   // R6 AND masks bit 8
    do_pass(16'h786D, 16'h0201, 16'h0, 16'h03E1, 1'b0, 5'd31, 2, 1'b1);  // T4 only, start poked
    do_pass(16'h786D, 16'h0041, 16'h0, 16'h01E1, 1'b0, 5'd0, 1, 1'b1);   // back to 10 full
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule